// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a guest access to an I/O port must leave the guest. A port permission bitmap lives in memory at a programmable base address, with one bit per port number. A request presents a port number, an access descriptor word and an enable. The enable is the I/O intercept bit from the general intercept vector. When the enable is low the check ends at once and the access is allowed. When it is high, the block reads a 16-bit window of the bitmap that starts at the byte holding the port's bit. It builds that window from two byte reads, little-endian. It then tests one bit for every byte the access covers.

At the end of every check the block pulses `done`. The exit request is raised together with `done` when any covered bit is set. In the same cycle the block presents two values for the exit sequencer to record. One is the exit information word: the descriptor with the port number ORed into its upper half. The other is the address of the next instruction. The bitmap contents and the exit sequence itself belong to other blocks.

Top module: `iopm_check`

## Requirements
- R1: After reset, `done`, `exit_req` and `mem_rd` are low and `req_ready` is high.
- R2: A request accepted with `io_en` low issues no memory read. It raises `done` in the next cycle with `exit_req` low, whatever the bitmap holds.
- R3: A request accepted with `io_en` high issues two byte reads in consecutive cycles. The first is at `bmp_base + (port >> 3)` and the second is at that address plus one. The first read is issued in the cycle after acceptance.
- R4: The access size is descriptor bits [6:4]. The window is `{second byte, first byte}`. The access exits when any bit of `((1 << size) - 1) << port[2:0]` is set in the window. This is the same as asking whether any bitmap bit for the ports `port .. port+size-1` is set, where bit `p` is bit `p mod 8` of byte `p >> 3`.
- R5: An access of size 0 never exits, even over a bitmap of all ones.
- R6: At every `done`, `exit_info` equals `desc | (port << 16)` for the accepted request, for exits and for allowed accesses alike.
- R7: At every `done`, `exit_next_pc` equals `cur_pc + insn_len` sampled at acceptance, modulo 2^PC_W.
- R8: An enabled check raises `done` four cycles after acceptance. `req_ready` is low from the cycle after acceptance until the `done` cycle. While `req_ready` is low, requests are ignored and no read is issued.
- R9: `done` is a single-cycle pulse, given once per accepted request, and `exit_req` is high only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Check request |
| req_ready | output | 1 | Block idle; a request is accepted when both are high |
| io_en | input | 1 | I/O intercept enable from the general intercept vector |
| port | input | PORT_W | Port number accessed |
| desc | input | DESC_W | Access descriptor; size in bits [6:4] |
| cur_pc | input | PC_W | Address of the current instruction |
| insn_len | input | LEN_W | Length of the current instruction |
| bmp_base | input | ADDR_W | Byte address of the bitmap |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Check finished (pulse) |
| exit_req | output | 1 | Access must exit (valid with `done`) |
| exit_info | output | DESC_W | Descriptor with port in upper half |
| exit_next_pc | output | PC_W | Next-instruction address |

## Verification
The bench sweeps every size against the lowest and highest port numbers over several bitmap patterns. Its expected result is computed bit by bit from the port range, not from a shifted mask. The sweep hits offsets where the mask spills into the second byte; a design that read only one byte, or put the bytes in big-endian order, would miss exits there. The top ports wrap the window past the last full bitmap byte, which catches address arithmetic that drops the carry. Size 0 over an all-ones bitmap would expose an off-by-one mask. Disabled requests over the same bitmap would expose a design that reads or exits anyway. A request held high through a busy check would show a design that accepts a second request or overwrites the latched port.

// File: rtl/iopm_pkg.sv
package iopm_pkg;

  localparam int SIZE_LSB = 4;
  localparam int SIZE_W   = 3;
  localparam int WIN_W    = 16;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2,
    F_CAP  = 2'd3
  } fetch_st_e;

  // access size field of the descriptor (bits [6:4])
  function automatic logic [SIZE_W-1:0] acc_size(input logic [6:0] d_lo);
    return d_lo[SIZE_LSB +: SIZE_W];
  endfunction

  // covered-port mask, placed at the port's bit offset within the window
  function automatic logic [WIN_W-1:0] win_mask(input logic [SIZE_W-1:0] sz,
                                                 input logic [2:0] off);
    logic [WIN_W-1:0] base_m;
    base_m = (WIN_W'(1) << sz) - WIN_W'(1);
    return base_m << off;
  endfunction

endpackage

// File: rtl/iopm_mask_hit.sv
module iopm_mask_hit
  import iopm_pkg::*;
(
  input  logic [6:0]       desc_lo,
  input  logic [2:0]       bit_off,
  input  logic [WIN_W-1:0] window,
  output logic             hit
);

  logic [WIN_W-1:0] mask;
  logic [WIN_W-1:0] hit_bits;

  assign mask = win_mask(acc_size(desc_lo), bit_off);

  for (genvar i = 0; i < WIN_W; i++) begin : g_bit
    assign hit_bits[i] = mask[i] & window[i];
  end

  assign hit = |hit_bits;

endmodule

// File: rtl/iopm_fetch.sv
module iopm_fetch
  import iopm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              win_valid,
  output logic [WIN_W-1:0]  window
);

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (start) begin
          st_q   <= F_LO;
          addr_q <= start_addr;
        end
        F_LO:  st_q <= F_HI;
        F_HI: begin
          lo_q <= mem_rdata;
          st_q <= F_CAP;
        end
        F_CAP: st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = (st_q == F_LO) || (st_q == F_HI);
    mem_addr = (st_q == F_HI) ? addr_q + ADDR_W'(1) : addr_q;
  end

  assign win_valid = (st_q == F_CAP);
  assign window    = {mem_rdata, lo_q};

endmodule

// File: rtl/iopm_check.sv
module iopm_check
  import iopm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DESC_W = 32,
  parameter int PC_W   = 32,
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              io_en,
  input  logic [PORT_W-1:0] port,
  input  logic [DESC_W-1:0] desc,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [ADDR_W-1:0] bmp_base,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              exit_req,
  output logic [DESC_W-1:0] exit_info,
  output logic [PC_W-1:0]   exit_next_pc
);

  localparam int BYTE_IDX_W = PORT_W - 3;
  localparam int INFO_SHIFT = 16;

  logic              busy_q;
  logic              accept;
  logic              fetch_go;
  logic [ADDR_W-1:0] fetch_addr;
  logic              win_valid;
  logic [WIN_W-1:0]  window;
  logic              hit;
  logic [PORT_W-1:0] port_q;
  logic [DESC_W-1:0] desc_q;
  logic [DESC_W-1:0] info_q;
  logic [PC_W-1:0]   npc_q;
  logic [DESC_W-1:0] info_now;
  logic [PC_W-1:0]   npc_now;

  assign req_ready  = !busy_q;
  assign accept     = req_valid && req_ready;
  assign fetch_go   = accept && io_en;
  assign fetch_addr = bmp_base + ADDR_W'(port[PORT_W-1 -: BYTE_IDX_W]);
  assign info_now   = desc | (DESC_W'(port) << INFO_SHIFT);
  assign npc_now    = cur_pc + PC_W'(insn_len);

  iopm_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_go),
    .start_addr (fetch_addr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .win_valid  (win_valid),
    .window     (window)
  );

  iopm_mask_hit mask_i (
    .desc_lo (desc_q[6:0]),
    .bit_off (port_q[2:0]),
    .window  (window),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      done         <= 1'b0;
      exit_req     <= 1'b0;
      exit_info    <= '0;
      exit_next_pc <= '0;
      port_q       <= '0;
      desc_q       <= '0;
      info_q       <= '0;
      npc_q        <= '0;
    end else begin
      done     <= 1'b0;
      exit_req <= 1'b0;
      if (accept) begin
        port_q <= port;
        desc_q <= desc;
        info_q <= info_now;
        npc_q  <= npc_now;
        if (io_en) begin
          busy_q <= 1'b1;
        end else begin
          done         <= 1'b1;
          exit_info    <= info_now;
          exit_next_pc <= npc_now;
        end
      end
      if (win_valid) begin
        busy_q       <= 1'b0;
        done         <= 1'b1;
        exit_req     <= hit;
        exit_info    <= info_q;
        exit_next_pc <= npc_q;
      end
    end
  end

endmodule

// File: rtl/iopm_check_sva.sv
module iopm_check_sva #(
  parameter int PORT_W = 16,
  parameter int DESC_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              io_en,
  input logic [PORT_W-1:0] port,
  input logic [DESC_W-1:0] desc,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              exit_req,
  input logic [DESC_W-1:0] exit_info,
  input logic              win_valid
);

  a_r2_skip_path: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !io_en) |=> (done && !exit_req && !mem_rd));

  a_r3_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r6_info_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !io_en) |=>
      (exit_info == ($past(desc) | (DESC_W'($past(port)) << 16))));

  a_r8_busy_reads: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

  a_r9_exit_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> done);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_valid && req_ready));

  a_r4_window_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> done);

endmodule

bind iopm_check iopm_check_sva #(
  .PORT_W (PORT_W),
  .DESC_W (DESC_W),
  .ADDR_W (ADDR_W)
) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .io_en     (io_en),
  .port      (port),
  .desc      (desc),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .done      (done),
  .exit_req  (exit_req),
  .exit_info (exit_info),
  .win_valid (win_valid)
);

// File: tb/iopm_check_tb.sv
`timescale 1ns/1ps
module iopm_check_tb_top;

  localparam int PORT_W = 16;
  localparam int DESC_W = 32;
  localparam int PC_W   = 32;
  localparam int LEN_W  = 4;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] BASE = 32'h0004_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic io_en = 1'b0;
  logic [PORT_W-1:0] port = '0;
  logic [DESC_W-1:0] desc = '0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [LEN_W-1:0] insn_len = '0;
  logic [ADDR_W-1:0] bmp_base = BASE;
  logic mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic done, exit_req;
  logic [DESC_W-1:0] exit_info;
  logic [PC_W-1:0] exit_next_pc;

  int n_chk = 0;
  int n_fail = 0;
  int pat_mode = 0;
  int rd_total = 0;
  logic [ADDR_W-1:0] rd_last = '0;
  logic [ADDR_W-1:0] rd_prev = '0;

  always #2.5 clk = ~clk;

  iopm_check #(.PORT_W(PORT_W), .DESC_W(DESC_W), .PC_W(PC_W),
               .LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .io_en(io_en), .port(port), .desc(desc), .cur_pc(cur_pc),
    .insn_len(insn_len), .bmp_base(bmp_base), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .exit_req(exit_req), .exit_info(exit_info), .exit_next_pc(exit_next_pc)
  );

  // bitmap byte as a function of its index, per pattern
  function automatic logic [7:0] bmp_byte(input int mode, input int idx);
    case (mode)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'((idx * 37 + (idx >> 3) * 11) ^ 8'h5A);
      default: return (idx % 5 == 0) ? (8'h01 << (idx % 8)) : 8'h00;
    endcase
  endfunction

  function automatic bit port_bit(input int mode, input int p);
    logic [7:0] b;
    b = bmp_byte(mode, p / 8);
    return b[p % 8];
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= bmp_byte(pat_mode, int'(mem_addr - BASE));
      rd_total  <= rd_total + 1;
      rd_prev   <= rd_last;
      rd_last   <= mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_check(input int p, input int sz, input bit en,
                           input logic [PC_W-1:0] pc, input logic [LEN_W-1:0] ln);
    int lat;
    int rd0;
    bit exp_exit;
    logic [DESC_W-1:0] d;
    d = 32'hA500_0003 | (DESC_W'(sz) << 4);
    @(negedge clk);
    port = PORT_W'(p); desc = d; io_en = en; cur_pc = pc; insn_len = ln;
    req_valid = 1'b1;
    rd0 = rd_total;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 20);
    exp_exit = 1'b0;
    if (en) for (int j = 0; j < sz; j++) if (port_bit(pat_mode, p + j)) exp_exit = 1'b1;
    chk(lat == (en ? 4 : 1), en ? "R8 latency" : "R2 latency", lat, en ? 4 : 1);
    chk(exit_req == exp_exit, (sz == 0) ? "R5 exit" : "R4 exit", exit_req, exp_exit);
    chk(exit_info == (d | (DESC_W'(p) << 16)), "R6 info", exit_info, d | (DESC_W'(p) << 16));
    chk(exit_next_pc == PC_W'(pc + PC_W'(ln)), "R7 next pc", exit_next_pc, PC_W'(pc + PC_W'(ln)));
    chk((rd_total - rd0) == (en ? 2 : 0), en ? "R3 read count" : "R2 read count",
        rd_total - rd0, en ? 2 : 0);
    if (en)
      chk(rd_prev == BASE + ADDR_W'(p >> 3) && rd_last == BASE + ADDR_W'(p >> 3) + 1,
          "R3 read address", rd_prev, BASE + ADDR_W'(p >> 3));
    @(negedge clk);
    chk(!done && !exit_req, "R9 single pulse", done, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !exit_req && !mem_rd && req_ready, "R1 reset state",
        {done, exit_req, mem_rd, req_ready}, 4'b0001);

    // disabled checks over a full bitmap
    pat_mode = 1;
    for (int s = 0; s < 8; s++) run_check(s * 9 + 1, s, 1'b0, 32'h1000, 4'd3);

    // sweeps: all sizes, low and high ports, several patterns
    for (int m = 0; m < 4; m++) begin
      pat_mode = m;
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 40; p++) run_check(p, s, 1'b1, 32'h0000_2000 + p, 4'd2);
        for (int p = 65528; p < 65536; p++) run_check(p, s, 1'b1, 32'h0000_3000, 4'd1);
      end
    end

    // next-instruction address wraps
    pat_mode = 2;
    run_check(100, 2, 1'b1, 32'hFFFF_FFFF, 4'd2);
    run_check(7, 4, 1'b0, 32'hFFFF_FFFE, 4'd15);

    // request held through a busy check is ignored (R8)
    begin
      int nd;
      pat_mode = 0;
      @(negedge clk);
      port = 16'h0123; desc = 32'h0000_0010; io_en = 1'b1; req_valid = 1'b1;
      @(posedge clk);
      #1 port = 16'h0456; desc = 32'h0000_0070;
      nd = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (c < 3) chk(!req_ready, "R8 ready low while busy", req_ready, 0);
        if (done) nd++;
      end
      req_valid = 1'b0;
      chk(nd == 1, "R8 one done", nd, 1);
      chk(exit_info == 32'h0123_0010, "R8 first request kept", exit_info, 32'h0123_0010);
      repeat (6) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule